// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block produces the column addresses of one SDRAM read or write burst, as the device side of a memory would walk them. A mode-load command copies the burst settings from the address bus: the length (1, 2, 4, 8 beats or a whole 256-column row), the wrap order (sequential or interleaved) and whether writes burst or move only one beat. Each read or write command latches a starting column. From the next cycle on, the block presents one column per clock until the burst ends, is cut short by a terminate strobe, or is replaced by a newer command.

All inputs are sampled on the rising clock edge. The outputs come straight from state registers through address logic with no extra pipeline stage. The first beat therefore appears in the cycle after the command edge. A neighbouring data-path block can use `col_valid` and `col_last` to frame each transfer.

Top module: `sdram_burst_seq`

## Requirements
- R1: After reset `col_valid` and `col_last` are low, and the mode is length 1, sequential, with bursting writes, so a read moves exactly one beat.
- R2: A command with `cmd_type` 00 loads the mode from `addr` and starts no burst. `addr[2:0]` sets the length: 000=1, 001=2, 010=4, 011=8, 111=full row. The reserved codes 100 to 110 act as length 1. `addr[3]`=1 selects interleaved order. `addr[9]`=1 makes writes single-beat. All other address bits are ignored.
- R3: `cmd_type` 01 is a read and 10 is a write. The start column is `addr[7:0]`. The first beat shows that column in the cycle after the command edge, and `col_valid` stays high for one cycle per beat.
- R4: In sequential order with length BL, beat k is the start column with its low log2(BL) bits replaced by (start + k) mod BL. The upper bits keep their starting value.
- R5: In interleaved order with length BL, beat k is the start column with its low log2(BL) bits XORed with k.
- R6: A full-row burst steps through the columns incrementing modulo 256 from the start and wraps past 255. It uses this order even when interleaved is selected. It runs until it is terminated or replaced, and `col_last` never rises during it.
- R7: `col_last` is high exactly on the final beat of a fixed-length burst, and `col_valid` is low in the cycle after that beat unless a new command arrived.
- R8: When single-beat writes are selected, a write moves one beat with `col_last` high, while reads keep the programmed length. When the mode is clear, writes use the programmed length.
- R9: If `term` is sampled high during a burst, the beat shown at that edge is the final one and `col_valid` is low in the next cycle. When no burst is running, `term` has no effect.
- R10: A read or write command during a burst abandons the old burst, and the new burst's first beat appears in the next cycle. This holds even when `term` is high at the same edge.
- R11: A mode load during a burst does not change that burst. The new settings apply from the next read or write command onward.
- R12: `cmd_type` 11 is a no-op. It does not start, stop or alter a burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command strobe |
| cmd_type | input | 2 | 00 mode load, 01 read, 10 write, 11 no-op |
| addr | input | 12 | Mode key or start column (low 8 bits) |
| term | input | 1 | Ends the running burst after the current beat |
| col | output | 8 | Column of the current beat |
| col_valid | output | 1 | A burst beat is being presented |
| col_last | output | 1 | Final beat of a fixed-length burst |

## Verification
The bench sweeps every start column for each fixed length in both orders. A design that wrapped over too many bits, or carried into the upper column bits, would show wrong columns at the row-block edges. A full-row burst is started near column 255 with interleaving requested. This exposes a design that fails to wrap, applies XOR order to a full row, or raises `col_last` at 256 beats. The bench also checks commands that collide with a running burst: a new command at the same edge as `term`, a mode load in the middle of a burst, and a no-op in the middle of a burst. A design that honoured the wrong one, or let the new mode leak into the running burst, would drop or corrupt beats there. Reserved length codes and the single-beat write mode are also checked, since a misdecode would produce bursts of the wrong length.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

    typedef enum logic [1:0] {
        CMD_MODE  = 2'b00,
        CMD_READ  = 2'b01,
        CMD_WRITE = 2'b10,
        CMD_NOP   = 2'b11
    } cmd_e;

    // bit positions of the mode key on the address bus
    localparam int KEY_LEN_LSB  = 0;
    localparam int KEY_ILV_BIT  = 3;
    localparam int KEY_WSGL_BIT = 9;

    localparam logic [2:0] LEN_1    = 3'b000;
    localparam logic [2:0] LEN_2    = 3'b001;
    localparam logic [2:0] LEN_4    = 3'b010;
    localparam logic [2:0] LEN_8    = 3'b011;
    localparam logic [2:0] LEN_FULL = 3'b111;

    // longest fixed burst is 2**MAX_LG beats
    localparam int MAX_LG = 3;
    localparam int LG_W   = $clog2(MAX_LG + 1);

    typedef struct packed {
        logic [2:0] len_code;
        logic       ilv;
        logic       wr_single;
    } mode_t;

    function automatic logic [LG_W-1:0] len_lg(input logic [2:0] code);
        logic [LG_W-1:0] r;
        case (code)
            LEN_2:   r = LG_W'(1);
            LEN_4:   r = LG_W'(2);
            LEN_8:   r = LG_W'(3);
            default: r = LG_W'(0);
        endcase
        return r;
    endfunction

    function automatic logic len_legal(input logic [2:0] code);
        return (code == LEN_1) || (code == LEN_2) || (code == LEN_4) ||
               (code == LEN_8) || (code == LEN_FULL);
    endfunction

endpackage

// File: rtl/sbs_mode_reg.sv
module sbs_mode_reg
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] key,
    output mode_t             mode
);

    mode_t mode_d, mode_q;
    logic [2:0] code_in;

    always_comb begin
        mode_d  = mode_q;
        code_in = key[KEY_LEN_LSB +: 3];
        if (load) begin
            // reserved length codes collapse to a single beat
            mode_d.len_code  = len_legal(code_in) ? code_in : LEN_1;
            mode_d.ilv       = key[KEY_ILV_BIT];
            mode_d.wr_single = key[KEY_WSGL_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= '0;
        else        mode_q <= mode_d;
    end

    assign mode = mode_q;

    p_code_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        len_legal(mode_q.len_code));

    p_load_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> mode_q == $past(mode_q));

endmodule

// File: rtl/sbs_col_gen.sv
module sbs_col_gen
    import sbs_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] start,
    input  logic [COL_W-1:0] beat,
    input  logic [LG_W-1:0]  lg,
    input  logic             full,
    input  logic             ilv,
    output logic [COL_W-1:0] col
);

    logic [COL_W-1:0] wrap_mask;
    logic [COL_W-1:0] low_part;

    // bit i wraps when it lies inside the burst window
    for (genvar i = 0; i < COL_W; i++) begin : g_mask
        assign wrap_mask[i] = full | (int'(lg) > i);
    end

    always_comb begin
        if (ilv && !full) low_part = start ^ beat;
        else              low_part = start + beat;
        col = (start & ~wrap_mask) | (low_part & wrap_mask);
    end

endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int COL_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_type,
    input  logic [ADDR_W-1:0] addr,
    input  logic              term,
    output logic [COL_W-1:0]  col,
    output logic              col_valid,
    output logic              col_last
);

    typedef struct packed {
        logic             active;
        logic [COL_W-1:0] start;
        logic [COL_W-1:0] beat;
        logic [LG_W-1:0]  lg;
        logic             full;
        logic             ilv;
    } burst_t;

    burst_t bst_d, bst_q;
    mode_t  mode;
    cmd_e   cmd;
    logic   mode_load, rw_cmd, is_write, one_beat, last_beat;
    logic [COL_W-1:0] last_idx;

    assign cmd       = cmd_e'(cmd_type);
    assign mode_load = cmd_valid && (cmd == CMD_MODE);
    assign rw_cmd    = cmd_valid && ((cmd == CMD_READ) || (cmd == CMD_WRITE));
    assign is_write  = (cmd == CMD_WRITE);
    assign one_beat  = is_write && mode.wr_single;

    sbs_mode_reg #(.ADDR_W(ADDR_W)) u_mode (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (mode_load),
        .key   (addr),
        .mode  (mode)
    );

    sbs_col_gen #(.COL_W(COL_W)) u_gen (
        .start (bst_q.start),
        .beat  (bst_q.beat),
        .lg    (bst_q.lg),
        .full  (bst_q.full),
        .ilv   (bst_q.ilv),
        .col   (col)
    );

    always_comb begin
        last_idx  = (COL_W'(1) << bst_q.lg) - COL_W'(1);
        last_beat = bst_q.active && !bst_q.full && (bst_q.beat == last_idx);
    end

    always_comb begin
        bst_d = bst_q;
        if (rw_cmd) begin
            bst_d.active = 1'b1;
            bst_d.start  = addr[COL_W-1:0];
            bst_d.beat   = '0;
            bst_d.lg     = one_beat ? '0 : len_lg(mode.len_code);
            bst_d.full   = !one_beat && (mode.len_code == LEN_FULL);
            bst_d.ilv    = mode.ilv;
        end else if (bst_q.active) begin
            if (term || last_beat) bst_d.active = 1'b0;
            else                   bst_d.beat   = bst_q.beat + COL_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bst_q <= '0;
        else        bst_q <= bst_d;
    end

    assign col_valid = bst_q.active;
    assign col_last  = last_beat;

    p_cmd_starts_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rw_cmd |=> col_valid && (col == $past(addr[COL_W-1:0])));

    p_last_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
        col_last && !rw_cmd |=> !col_valid);

    p_term_ends_r9: assert property (@(posedge clk) disable iff (!rst_n)
        col_valid && term && !rw_cmd |=> !col_valid);

    p_single_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && (cmd == CMD_WRITE) && mode.wr_single |=> col_last);

    p_burst_continues_r6: assert property (@(posedge clk) disable iff (!rst_n)
        col_valid && !col_last && !term |=> col_valid);

    p_idle_stays_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !col_valid && !rw_cmd |=> !col_valid);

endmodule

// File: tb/sdram_burst_seq_test.sv
module sdram_burst_seq_test;

    localparam int ADDR_W = 12;
    localparam int COL_W  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic [1:0]        cmd_type = 2'b11;
    logic [ADDR_W-1:0] addr = '0;
    logic              term = 1'b0;
    logic [COL_W-1:0]  col;
    logic              col_valid, col_last;

    int errors = 0;
    int checks = 0;

    // bench copy of the programmed mode
    int  m_lg = 0;
    bit  m_full = 0, m_ilv = 0, m_ws = 0;

    sdram_burst_seq #(.ADDR_W(ADDR_W), .COL_W(COL_W)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_type(cmd_type),
        .addr(addr), .term(term), .col(col), .col_valid(col_valid),
        .col_last(col_last)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_col(int start, int k, int lg, bit ilv, bit full);
        int n, base, lo;
        n    = full ? 256 : (1 << lg);
        base = start - (start % n);
        lo   = start % n;
        if (ilv && !full) return base + (lo ^ (k % n));
        return base + ((lo + k) % n);
    endfunction

    // all tasks start and end just after a falling edge
    task automatic mrs(input int code, input bit ilv, input bit ws);
        cmd_valid = 1'b1; cmd_type = 2'b00;
        addr = ADDR_W'(code) | (ADDR_W'(ilv) << 3) | (ADDR_W'(ws) << 9) |
               ADDR_W'(12'h470);
        @(negedge clk);
        cmd_valid = 1'b0; cmd_type = 2'b11;
        chk("R2 mode load starts no burst", int'(col_valid), 0);
        m_full = (code == 7);
        m_lg   = (code <= 3) ? code : 0;
        m_ilv  = ilv;
        m_ws   = ws;
    endtask

    task automatic issue(input bit wr, input int start);
        cmd_valid = 1'b1; cmd_type = wr ? 2'b10 : 2'b01;
        addr = ADDR_W'(start) | ADDR_W'(12'hA00);
    endtask

    // fixed-length burst, checked beat by beat, then the idle cycle after
    task automatic burst(input bit wr, input int start, input string req);
        int lg, n;
        lg = (wr && m_ws) ? 0 : m_lg;
        n  = 1 << lg;
        issue(wr, start);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            cmd_valid = 1'b0;
            chk(req, int'(col_valid), 1);
            chk(req, int'(col), exp_col(start, k, lg, m_ilv, 1'b0));
            chk({req, " R7 last"}, int'(col_last), (k == n - 1) ? 1 : 0);
        end
        @(negedge clk);
        chk({req, " R7 ends"}, int'(col_valid), 0);
        chk({req, " R7 last low"}, int'(col_last), 0);
    endtask

    initial begin
        #(8 * 150000);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", int'(col_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid after reset", int'(col_valid), 0);
        chk("R1 last after reset", int'(col_last), 0);
        burst(1'b0, 8'h5A, "R1 default length one");

        // R12: no-op while idle
        cmd_valid = 1'b1; cmd_type = 2'b11; addr = 12'h0FF;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R12 no-op idle", int'(col_valid), 0);

        // R9: term while idle
        term = 1'b1;
        @(negedge clk);
        term = 1'b0;
        chk("R9 term idle", int'(col_valid), 0);

        // R3 R4 R5: every start column, every fixed length, both orders
        for (int code = 0; code < 4; code++) begin
            for (int il = 0; il < 2; il++) begin
                mrs(code, il[0], 1'b0);
                for (int s = 0; s < 256; s++)
                    burst(1'b0, s, il ? "R5 R3 interleaved" : "R4 R3 sequential");
            end
        end

        // R2: reserved codes behave as length one
        for (int code = 4; code < 7; code++) begin
            mrs(code, 1'b1, 1'b0);
            burst(1'b0, 8'h37, "R2 reserved code");
        end

        // R8: single-beat writes, reads keep length
        mrs(3, 1'b0, 1'b1);
        burst(1'b1, 8'h45, "R8 single write");
        burst(1'b0, 8'h45, "R8 read keeps length");
        mrs(3, 1'b1, 1'b0);
        burst(1'b1, 8'h45, "R8 write bursts");

        // R6 R9: full row, interleave ignored, wraps past 255
        mrs(7, 1'b1, 1'b0);
        issue(1'b0, 8'hFD);
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            cmd_valid = 1'b0;
            chk("R6 full valid", int'(col_valid), 1);
            chk("R6 full column", int'(col), (8'hFD + k) % 256);
            chk("R6 full no last", int'(col_last), 0);
            if (k == 299) term = 1'b1;
        end
        @(negedge clk);
        term = 1'b0;
        chk("R9 full term ends", int'(col_valid), 0);

        // R9: term in a fixed burst
        mrs(3, 1'b0, 1'b0);
        issue(1'b0, 8'h10);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            cmd_valid = 1'b0;
            chk("R9 beat before term", int'(col), 8'h10 + k);
            if (k == 2) term = 1'b1;
        end
        @(negedge clk);
        term = 1'b0;
        chk("R9 term ends burst", int'(col_valid), 0);

        // R10: new command with term at the same edge replaces the burst
        issue(1'b0, 8'h20);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            cmd_valid = 1'b0;
            chk("R10 old burst", int'(col), 8'h20 + k);
            if (k == 3) begin issue(1'b1, 8'h84); term = 1'b1; end
        end
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            cmd_valid = 1'b0; term = 1'b0;
            chk("R10 new burst valid", int'(col_valid), 1);
            chk("R10 new burst column", int'(col), exp_col(8'h84, k, 3, 1'b0, 1'b0));
        end
        @(negedge clk);
        chk("R10 new burst ends", int'(col_valid), 0);

        // R11 R12: mode load and no-op during a burst
        issue(1'b0, 8'h30);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            cmd_valid = 1'b0; cmd_type = 2'b11;
            chk("R11 burst unchanged", int'(col), exp_col(8'h30, k, 3, 1'b0, 1'b0));
            chk("R11 last position", int'(col_last), (k == 7) ? 1 : 0);
            if (k == 1) begin
                cmd_valid = 1'b1; cmd_type = 2'b00; addr = 12'h009;
            end
            if (k == 4) begin
                cmd_valid = 1'b1; cmd_type = 2'b11; addr = 12'h0FF;
            end
        end
        @(negedge clk);
        chk("R11 ends", int'(col_valid), 0);
        m_lg = 1; m_full = 0; m_ilv = 1; m_ws = 0;
        burst(1'b0, 8'h33, "R11 new mode applies");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule